// File: doc/BRIEF.md
# Multithreaded Core Issue Arbiter

This block decides, every clock cycle, which hardware thread issues an operation in each core of a cluster of small expression-evaluation cores. Each core carries a fixed number of thread slots. Among the slots that are ready and not waiting on a long operation, a fixed priority picks one, with slot 0 highest. A thread whose complex operation is still in flight is passed over, and the other threads of its core keep issuing. The simple functional units are fully pipelined, so a core may issue on every cycle, and the same thread may issue on consecutive cycles.

All cores share one complex-operation unit for logarithm, divide, exponent and float-to-integer conversion. A core whose selected thread wants a complex operation raises a request. One requesting core per cycle is granted, in round-robin order. The block sends the granted operation to the unit, tagged with core and thread. It marks that thread busy and models the unit as a pipeline of fixed latency whose results come back in order. When the result returns, the block raises a one-cycle completion pulse for that thread and frees it. A core that loses arbitration issues nothing in that cycle and keeps requesting until it wins.

Top module: `mt_issue_arb`

## Requirements
- R1: After reset no thread is busy, no completion is pending, and the round-robin pointer selects core 0 first.
- R2: In each core at most one thread issues per cycle, and it is the lowest-numbered slot that is ready and not busy. A slot that is not ready never issues.
- R3: A thread granted a complex operation is busy and is not issued until its result returns. Lower-priority ready threads of the same core keep issuing meanwhile.
- R4: Simple (non-complex) operations may issue from the same thread on back-to-back cycles with no bubble.
- R5: A core requests the complex unit when its selected thread's operation is complex. At most one core is granted per cycle: the first requester found at or after the pointer. The pointer then moves to the core after the granted one.
- R6: A core whose selected complex request is not granted issues no thread that cycle and requests again in the next cycle.
- R7: In the grant cycle the outputs carry valid, the core index, the thread slot and the 2-bit operation code of the granted request. The codes are 0 log, 1 divide, 2 exponent and 3 float-to-int, taken from bits [2i+1:2i] of the op input for flat thread index i = core*NT + slot.
- R8: Exactly LAT cycles after the grant cycle, done_o pulses for one cycle at the granted flat thread index. The thread is eligible again in the cycle after that pulse.
- R9: A core that keeps requesting is granted after at most NC-1 grants to other cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_i | input | NC*NT | Thread has an operation ready, flat index core*NT+slot |
| cplx_i | input | NC*NT | Ready operation of that thread is a complex one |
| op_i | input | 2*NC*NT | Complex operation code per thread |
| issue_o | output | NC*NT | Issue grant per thread, at most one per core |
| cx_vld_o | output | 1 | Complex unit receives an operation this cycle |
| cx_core_o | output | clog2(NC) | Core of the complex operation |
| cx_thr_o | output | clog2(NT) | Thread slot of the complex operation |
| cx_op_o | output | 2 | Operation code sent to the complex unit |
| done_o | output | NC*NT | Complex result returns for that thread |

## Verification
A wrong busy flag shows at the ports in the next cycle where the thread is ready. A stuck flag makes the core issue a lower slot instead of the expected one. A lost flag lets the thread issue before its done pulse. A wrong round-robin pointer changes which core appears on the complex outputs at the next contested grant. It also lengthens some core's wait past NC-1 grants within one rotation. A wrong tag pipeline moves or misroutes the done pulse by one or more cycles and then shifts every later issue of that thread.

// File: rtl/mt_issue_arb.sv
module mt_issue_arb #(
  parameter int NC  = 6,
  parameter int NT  = 4,
  parameter int LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NC*NT-1:0]     rdy_i,
  input  logic [NC*NT-1:0]     cplx_i,
  input  logic [2*NC*NT-1:0]   op_i,
  output logic [NC*NT-1:0]     issue_o,
  output logic                 cx_vld_o,
  output logic [((NC>1)?$clog2(NC):1)-1:0] cx_core_o,
  output logic [((NT>1)?$clog2(NT):1)-1:0] cx_thr_o,
  output logic [1:0]           cx_op_o,
  output logic [NC*NT-1:0]     done_o
);
  localparam int N  = NC*NT;
  localparam int CW = (NC > 1) ? $clog2(NC) : 1;
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [N-1:0]   busy, set;
  logic [CW-1:0]  rr;
  logic [LAT-1:0] pv;
  logic [CW-1:0]  pc [LAT];
  logic [TW-1:0]  pt [LAT];
  logic [NC-1:0]  has, req;
  logic [TW-1:0]  pick [NC];
  int             gi;

  always_comb begin
    issue_o = '0; done_o = '0; set = '0; has = '0; req = '0;
    cx_vld_o = 1'b0; cx_core_o = '0; cx_thr_o = '0; cx_op_o = '0; gi = 0;
    for (int c = 0; c < NC; c++) begin
      pick[c] = '0;
      for (int t = NT-1; t >= 0; t--)
        if (rdy_i[c*NT+t] && !busy[c*NT+t]) begin
          has[c]  = 1'b1;
          pick[c] = TW'(t);
        end
      req[c] = has[c] && cplx_i[c*NT+int'(pick[c])];
    end
    for (int k = NC-1; k >= 0; k--)
      if (req[(int'(rr)+k) % NC]) begin
        cx_vld_o  = 1'b1;
        cx_core_o = CW'((int'(rr)+k) % NC);
        cx_thr_o  = pick[(int'(rr)+k) % NC];
      end
    for (int c = 0; c < NC; c++)
      if (has[c] && (!req[c] || (cx_vld_o && int'(cx_core_o) == c)))
        issue_o[c*NT+int'(pick[c])] = 1'b1;
    if (cx_vld_o) begin
      gi      = int'(cx_core_o)*NT + int'(cx_thr_o);
      set[gi] = 1'b1;
      cx_op_o = op_i[2*gi +: 2];
    end
    if (pv[LAT-1])
      done_o[int'(pc[LAT-1])*NT + int'(pt[LAT-1])] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      rr   <= '0;
      pv   <= '0;
      for (int i = 0; i < LAT; i++) begin
        pc[i] <= '0;
        pt[i] <= '0;
      end
    end else begin
      busy <= (busy & ~done_o) | set;
      if (cx_vld_o)
        rr <= (int'(cx_core_o) == NC-1) ? '0 : cx_core_o + 1'b1;
      pv[0] <= cx_vld_o;
      pc[0] <= cx_core_o;
      pt[0] <= cx_thr_o;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pc[i] <= pc[i-1];
        pt[i] <= pt[i-1];
      end
    end
  end
endmodule

// File: rtl/mt_issue_arb_chk.sv
module mt_issue_arb_chk #(
  parameter int NC  = 6,
  parameter int NT  = 4,
  parameter int LAT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NC*NT-1:0]     rdy_i,
  input logic [NC*NT-1:0]     cplx_i,
  input logic [NC*NT-1:0]     issue_o,
  input logic                 cx_vld_o,
  input logic [((NC>1)?$clog2(NC):1)-1:0] cx_core_o,
  input logic [((NT>1)?$clog2(NT):1)-1:0] cx_thr_o,
  input logic [NC*NT-1:0]     done_o
);
  int gidx;
  assign gidx = int'(cx_core_o)*NT + int'(cx_thr_o);

  for (genvar c = 0; c < NC; c++) begin : g_core
    a_r2_one_per_core: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_o[c*NT +: NT]));
  end

  a_r2_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o & ~rdy_i) == '0);

  a_r7_grant_is_issued: assert property (@(posedge clk) disable iff (!rst_n)
    cx_vld_o |-> (issue_o[gidx] && cplx_i[gidx]));

  a_r3_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cx_vld_o |=> !issue_o[$past(gidx)]);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  a_r8_done_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o & issue_o) == '0);
endmodule

bind mt_issue_arb mt_issue_arb_chk #(.NC(NC), .NT(NT), .LAT(LAT)) u_chk (.*);

// File: tb/sim_mt_issue_arb.sv
`timescale 1ns/1ps
module sim_mt_issue_arb;
  localparam int NC = 6, NT = 4, LAT = 4, N = NC*NT;

  typedef struct packed {
    logic [N-1:0]  iss;
    logic          cv;
    logic [2:0]    cc;
    logic [1:0]    ct;
    logic [1:0]    co;
    logic [N-1:0]  done;
    logic [NC-1:0] req;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] rdy = '0, cplx = '0;
  logic [2*N-1:0] op = '0;
  logic [N-1:0] issue, done;
  logic cxv;
  logic [2:0] cxc;
  logic [1:0] cxt, cxo;

  always #2.5 clk = ~clk;

  mt_issue_arb #(.NC(NC), .NT(NT), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .rdy_i(rdy), .cplx_i(cplx), .op_i(op),
    .issue_o(issue), .cx_vld_o(cxv), .cx_core_o(cxc), .cx_thr_o(cxt),
    .cx_op_o(cxo), .done_o(done));

  item_t q[$];
  int nvec = 0, nbad = 0;
  bit [N-1:0] mbusy = '0;
  int mrr = 0;
  bit mpv[LAT];
  int mpi[LAT];
  int wcnt[NC];

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] c, input logic [2*N-1:0] o);
    item_t it;
    int pk[NC];
    bit rq[NC];
    int gc, gi;
    @(negedge clk);
    rdy = r; cplx = c; op = o;
    it = '0; gc = -1; gi = 0;
    if (mpv[LAT-1]) it.done[mpi[LAT-1]] = 1'b1;
    for (int k = 0; k < NC; k++) begin
      pk[k] = -1;
      for (int t = 0; t < NT; t++)
        if (pk[k] < 0 && r[k*NT+t] && !mbusy[k*NT+t]) pk[k] = t;
      rq[k] = (pk[k] >= 0) && c[k*NT+pk[k]];
      it.req[k] = rq[k];
    end
    for (int k = 0; k < NC; k++)
      if (gc < 0 && rq[(mrr+k)%NC]) gc = (mrr+k)%NC;
    for (int k = 0; k < NC; k++)
      if (pk[k] >= 0 && (!rq[k] || k == gc)) it.iss[k*NT+pk[k]] = 1'b1;
    if (gc >= 0) begin
      gi = gc*NT + pk[gc];
      it.cv = 1'b1; it.cc = 3'(gc); it.ct = 2'(pk[gc]); it.co = o[2*gi +: 2];
    end
    q.push_back(it);
    mbusy = mbusy & ~it.done;
    if (gc >= 0) begin
      mbusy[gi] = 1'b1;
      mrr = (gc + 1) % NC;
    end
    for (int i = LAT-1; i > 0; i--) begin
      mpv[i] = mpv[i-1]; mpi[i] = mpi[i-1];
    end
    mpv[0] = (gc >= 0); mpi[0] = gi;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      chk(issue === e.iss, "R2 R3 R4 R6 issue", 64'(issue), 64'(e.iss));
      chk(cxv === e.cv, "R5 grant valid", 64'(cxv), 64'(e.cv));
      if (e.cv)
        chk({cxc, cxt, cxo} === {e.cc, e.ct, e.co}, "R5 R7 core/thread/op",
            64'({cxc, cxt, cxo}), 64'({e.cc, e.ct, e.co}));
      chk(done === e.done, "R8 done", 64'(done), 64'(e.done));
      for (int k = 0; k < NC; k++) begin
        if (!e.req[k] || (cxv && int'(cxc) == k)) wcnt[k] = 0;
        else if (cxv) begin
          wcnt[k]++;
          chk(wcnt[k] <= NC-1, "R9 wait bound", 64'(wcnt[k]), 64'(NC-1));
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [N-1:0] c0;
    for (int k = 0; k < NC; k++) wcnt[k] = 0;
    for (int i = 0; i < LAT; i++) begin mpv[i] = 0; mpi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset
    step('0, '0, '0);
    step('0, '0, '0);
    // R1 R2 R4: all ready, simple ops, slot 0 back to back
    repeat (5) step('1, '0, '0);
    // R3 R5 R6 R7 R8 R9: every core's slot 0 wants a complex op
    c0 = '0;
    for (int k = 0; k < NC; k++) c0[k*NT] = 1'b1;
    repeat (30) step('1, c0, {N{2'b10}} ^ 48'h1b1b_e4e4_3636);
    // R2: sparse ready patterns, lowest slot wins
    step(24'h888888, '0, '0);
    step(24'hc4a2f1, '0, '0);
    step(24'h123456, '0, '0);
    step(24'h0f0f0f, '0, '0);
    // R3: slot 0 complex and slot 3 simple, others idle
    repeat (20) step(24'h999999, c0, {N{2'b01}});
    // mixed traffic
    for (int n = 0; n < 3000; n++)
      step(N'($urandom), N'($urandom) & N'($urandom) & N'($urandom), {$urandom, $urandom});
    repeat (LAT + 3) step('0, '0, '0);
    @(negedge clk); #2;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule